// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block rounds a binary mantissa that arrives with two extra low-order bits and a separate sticky bit. The two extra bits are the guard bit (upper) and the round bit (lower). The block removes them, decides from the rounding mode, the sign and the discarded information whether the kept part must grow by one unit in the last place, and performs that increment. The carry ripples across every word of the mantissa.

Each operation carries its own two-bit mode, so consecutive operations may round in different directions. The block reports four results:

- the rounded mantissa;
- the carry out of its top bit;
- a flag that says an increment took place;
- a flag that says the result is not exact.

A carry that turns the mantissa into 2.0 is passed on unchanged for the consumer to normalise. Exponents and storage formats are not handled here.

By default the result is registered. The output becomes valid one cycle after an input is accepted and holds until the next accepted input. A parameter selects a purely combinational variant instead.

Top module: `mant_rounder`

## Requirements
- R1: When guard, round and sticky are all zero, the output mantissa equals the input shifted right by two, and the carry, rounded-up and inexact outputs are all 0.
- R2: The inexact output is 1 exactly when at least one of guard, round or sticky is 1. The rounded-up output is never 1 while inexact is 0.
- R3: Mode 2'b00 (nearest): an increment happens only when guard is 1 and at least one of round, sticky or the kept LSB is 1. An exact tie therefore lands on the even value.
- R4: Mode 2'b01 (toward zero) never increments.
- R5: Mode 2'b10 (toward plus infinity) increments exactly when the result is inexact and the sign input is 0.
- R6: Mode 2'b11 (toward minus infinity) increments exactly when the result is inexact and the sign input is 1.
- R7: On an increment, rounded-up is 1 and the output mantissa equals the kept value plus one, with the carry crossing every internal word boundary. A kept value of all ones gives an all-zero mantissa with carry 1, and this result is not corrected.
- R8: In the registered variant, out_valid is 1 in the cycle after in_valid is 1. Reset clears out_valid and all result outputs to 0.
- R9: While in_valid is 0, the mantissa and flag outputs keep their last values and out_valid falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operation present |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mant | input | MANT_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits already shifted out below round |
| in_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result present |
| out_mant | output | MANT_W | Rounded mantissa |
| out_carry | output | 1 | Carry out of the increment |
| out_rounded_up | output | 1 | An increment was applied |
| out_inexact | output | 1 | The discarded bits were not all zero |

## Verification
The tie-to-even decision and the full-width carry ripple can both act on one operation. This happens when a kept value of all ones meets a pure tie in nearest mode: the odd LSB forces an increment, and that increment must overflow into the carry output with an all-zero mantissa. The bench provokes this case, and also a carry that crosses a word boundary in the directed modes. It judges every output field against values derived from the mode table alone. Back-to-back operations with different modes and signs confirm that the mode is taken from each operation separately.

// File: rtl/mant_rounder_pkg.sv
package mant_rounder_pkg;

    typedef enum logic [1:0] {
        RMODE_NEAREST = 2'b00,
        RMODE_ZERO    = 2'b01,
        RMODE_POS     = 2'b10,
        RMODE_NEG     = 2'b11
    } rmode_e;

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
    import mant_rounder_pkg::*;
(
    input  logic       sign,
    input  logic       guard,
    input  logic       rbit,
    input  logic       sticky,
    input  logic       lsb,
    input  logic [1:0] mode,
    output logic       inc,
    output logic       inexact
);

    always_comb begin
        inexact = guard | rbit | sticky;
        inc     = 1'b0;
        if (inexact) begin
            case (rmode_e'(mode))
                RMODE_NEAREST: inc = guard & (rbit | sticky | lsb);
                RMODE_ZERO:    inc = 1'b0;
                RMODE_POS:     inc = ~sign;
                RMODE_NEG:     inc = sign;
                default:       inc = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mant_word_incr.sv
module mant_word_incr #(
    parameter int MANT_W = 32,
    parameter int WORD_W = 16
) (
    input  logic [MANT_W-1:0] val,
    input  logic              inc,
    output logic [MANT_W-1:0] sum,
    output logic              carry
);

    localparam int NWORDS = (MANT_W + WORD_W - 1) / WORD_W;
    localparam int PAD_W  = NWORDS * WORD_W;

    logic [PAD_W-1:0] val_pad;
    logic [PAD_W-1:0] sum_pad;
    logic [NWORDS:0]  cy;

    assign val_pad = {{(PAD_W - MANT_W){1'b0}}, val};
    assign cy[0]   = inc;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W:0] part;
        assign part = {1'b0, val_pad[w*WORD_W +: WORD_W]} + {{WORD_W{1'b0}}, cy[w]};
        assign sum_pad[w*WORD_W +: WORD_W] = part[WORD_W-1:0];
        assign cy[w+1] = part[WORD_W];
    end

    assign sum = sum_pad[MANT_W-1:0];

    if (PAD_W == MANT_W) begin : g_even
        assign carry = cy[NWORDS];
    end else begin : g_pad
        assign carry = sum_pad[MANT_W];
    end

endmodule

// File: rtl/mant_rounder.sv
module mant_rounder #(
    parameter int MANT_W  = 32,
    parameter int WORD_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [MANT_W+1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [MANT_W-1:0] out_mant,
    output logic              out_carry,
    output logic              out_rounded_up,
    output logic              out_inexact
);

    typedef struct packed {
        logic              valid;
        logic [MANT_W-1:0] mant;
        logic              carry;
        logic              up;
        logic              inexact;
    } res_t;

    logic [MANT_W-1:0] kept;
    logic              inc;
    logic              inex;
    logic [MANT_W-1:0] sum;
    logic              cout;
    res_t              res_d;
    res_t              res_q;

    assign kept = in_mant[MANT_W+1:2];

    mant_round_decide u_decide (
        .sign    (in_sign),
        .guard   (in_mant[1]),
        .rbit    (in_mant[0]),
        .sticky  (in_sticky),
        .lsb     (in_mant[2]),
        .mode    (in_mode),
        .inc     (inc),
        .inexact (inex)
    );

    mant_word_incr #(.MANT_W(MANT_W), .WORD_W(WORD_W)) u_incr (
        .val   (kept),
        .inc   (inc),
        .sum   (sum),
        .carry (cout)
    );

    always_comb begin
        res_d = res_q;
        res_d.valid = in_valid;
        if (in_valid || !REG_OUT) begin
            res_d.mant    = sum;
            res_d.carry   = cout;
            res_d.up      = inc;
            res_d.inexact = inex;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign out_valid      = res_q.valid;
    assign out_mant       = res_q.mant;
    assign out_carry      = res_q.carry;
    assign out_rounded_up = res_q.up;
    assign out_inexact    = res_q.inexact;

endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
    parameter int MANT_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sticky,
    input logic [MANT_W+1:0] in_mant,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [MANT_W-1:0] out_mant,
    input logic              out_carry,
    input logic              out_rounded_up,
    input logic              out_inexact
);

    AST_UP_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_rounded_up |-> out_inexact); // R2

    AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_carry |-> (out_rounded_up && out_mant == '0)); // R7

    if (REG_OUT) begin : g_seq
        AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R8

        AST_EXACT_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mant[1:0] == 2'b00 && !in_sticky)
            |=> (!out_inexact && !out_rounded_up && !out_carry)); // R1

        AST_TOWARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b01) |=> !out_rounded_up); // R4

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_mant) && $stable(out_inexact) && !out_valid)); // R9
    end

endmodule

bind mant_rounder mant_rounder_chk #(.MANT_W(MANT_W), .REG_OUT(REG_OUT)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sticky      (in_sticky),
    .in_mant        (in_mant),
    .in_mode        (in_mode),
    .out_valid      (out_valid),
    .out_mant       (out_mant),
    .out_carry      (out_carry),
    .out_rounded_up (out_rounded_up),
    .out_inexact    (out_inexact)
);

// File: tb/tb_mant_rounder.sv
`timescale 1ns/1ps
module tb_mant_rounder;

    localparam int MW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sign = 1'b0;
    logic [MW+1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic          out_valid;
    logic [MW-1:0] out_mant;
    logic          out_carry;
    logic          out_rounded_up;
    logic          out_inexact;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mant_rounder #(.MANT_W(MW), .WORD_W(16), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_mant(in_mant), .in_sticky(in_sticky), .in_mode(in_mode),
        .out_valid(out_valid), .out_mant(out_mant), .out_carry(out_carry),
        .out_rounded_up(out_rounded_up), .out_inexact(out_inexact)
    );

    typedef struct packed {
        logic [1:0]    mode;
        logic          sign;
        logic          sticky;
        logic [MW-1:0] kept;
        logic [1:0]    gr;
        logic [MW-1:0] emant;
        logic          ecarry;
        logic          eup;
        logic          einex;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b0, 32'h12345678, 2'b10, 32'h12345678, 1'b0, 1'b0, 1'b1}, // R3 tie even
        '{2'b00, 1'b0, 1'b0, 32'h12345679, 2'b10, 32'h1234567A, 1'b0, 1'b1, 1'b1}, // R3 tie odd
        '{2'b00, 1'b1, 1'b1, 32'h12345678, 2'b10, 32'h12345679, 1'b0, 1'b1, 1'b1}, // R3 sticky
        '{2'b00, 1'b0, 1'b0, 32'h12345678, 2'b11, 32'h12345679, 1'b0, 1'b1, 1'b1}, // R3 round bit
        '{2'b00, 1'b0, 1'b1, 32'h12345679, 2'b01, 32'h12345679, 1'b0, 1'b0, 1'b1}, // R3 no guard
        '{2'b00, 1'b0, 1'b0, 32'hABCDEF01, 2'b00, 32'hABCDEF01, 1'b0, 1'b0, 1'b0}, // R1
        '{2'b01, 1'b0, 1'b1, 32'hFFFFFFFF, 2'b11, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1}, // R4
        '{2'b10, 1'b0, 1'b1, 32'h0000FFFF, 2'b00, 32'h00010000, 1'b0, 1'b1, 1'b1}, // R5 R7
        '{2'b10, 1'b1, 1'b0, 32'h0000FFFF, 2'b01, 32'h0000FFFF, 1'b0, 1'b0, 1'b1}, // R5 neg
        '{2'b11, 1'b1, 1'b1, 32'h7FFFFFFF, 2'b00, 32'h80000000, 1'b0, 1'b1, 1'b1}, // R6 R7
        '{2'b11, 1'b0, 1'b0, 32'h00000001, 2'b10, 32'h00000001, 1'b0, 1'b0, 1'b1}, // R6 pos
        '{2'b00, 1'b0, 1'b0, 32'hFFFFFFFF, 2'b10, 32'h00000000, 1'b1, 1'b1, 1'b1}, // R7 R3 wrap
        '{2'b10, 1'b0, 1'b0, 32'hFFFFFFFF, 2'b00, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0}  // R1 R2
    };

    task automatic check(input string req, input logic [MW+3:0] act, input logic [MW+3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [MW+3:0] outs();
        return {out_valid, out_mant, out_carry, out_rounded_up, out_inexact};
    endfunction

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        in_mode   = v.mode;
        in_sign   = v.sign;
        in_sticky = v.sticky;
        in_mant   = {v.kept, v.gr};
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", outs(), '0);
        rst_n = 1'b1;

        // table walk, one operation then one idle cycle each
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R1-table vec%0d (R3 R4 R5 R6 R7 R2)", i), outs(),
                  {1'b1, VECS[i].emant, VECS[i].ecarry, VECS[i].eup, VECS[i].einex});
        end

        // R9: idle with changed data, outputs hold, valid drops
        in_mant   = {32'h0F0F0F0F, 2'b11};
        in_sticky = 1'b1;
        in_mode   = 2'b10;
        @(negedge clk);
        check("R9 hold", outs(),
              {1'b0, VECS[NV-1].emant, VECS[NV-1].ecarry, VECS[NV-1].eup, VECS[NV-1].einex});

        // back-to-back with differing modes and signs (R8 R5 R6)
        drive(VECS[9]);
        @(negedge clk);
        check("R8 b2b first (R6)", outs(),
              {1'b1, VECS[9].emant, VECS[9].ecarry, VECS[9].eup, VECS[9].einex});
        drive(VECS[7]);
        @(negedge clk);
        check("R8 b2b second (R5)", outs(),
              {1'b1, VECS[7].emant, VECS[7].ecarry, VECS[7].eup, VECS[7].einex});
        drive(VECS[11]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 wrap b2b", outs(),
              {1'b1, VECS[11].emant, VECS[11].ecarry, VECS[11].eup, VECS[11].einex});
        @(negedge clk);
        check("R9 valid drop", {31'b0, out_valid, 1'b0, 1'b0, 1'b0}, '0);

        // reset mid-stream clears state (R8)
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset again", outs(), '0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule